// File: doc/BRIEF.md
# Supply Startup and Fault Sequencer

This block is the supervisory state machine of a switching-regulator controller. On every clock it receives two sampled codes: one for the controller's own supply rail and one for die temperature. From these it drives three outputs. The first enables the high-voltage startup current source. The second allows the PWM engine to switch. The third flags the low-consumption condition.

The sequence runs as follows:
- The rail charges until it reaches a turn-on level, and switching then starts.
- If the rail sags below a minimum operating level while running, switching stops at once. The block then enters a quiet latch-off phase with the startup source off.
- It leaves latch-off only after the rail has drained to a third, lower level. It then re-arms the startup source.

This loop retries on its own for as long as an overload persists, and the supply resumes running once the overload clears. A thermal trip overrides every state, and a hysteresis band governs its release. Every threshold crossing must hold for a parameter number of consecutive samples before it counts.

Top module: `sup_seq_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, the state is STARTUP (`state_o` = 0). In this state `hv_src_en`=1, `sw_en`=0 and `low_pwr`=0.
- R2: In STARTUP, a supply code >= `V_ON_CODE` (default 128) moves the block to RUN (`state_o` = 1), with `hv_src_en`=0, `sw_en`=1 and `low_pwr`=0. The new state appears on the (N+1)th rising edge after the code is first sampled, where N = `QUAL_N` (default 4).
- R3: A threshold condition that holds for only N-1 consecutive samples changes no state.
- R4: In RUN, a supply code < `V_MIN_CODE` (default 78) moves the block to LATCHOFF (`state_o` = 2), with `sw_en`=0, `hv_src_en`=0 and `low_pwr`=1. A code between the two levels keeps RUN.
- R5: LATCHOFF is held while the supply code is above `V_LATCH_CODE` (default 49), even if the code rises above `V_ON_CODE`. A code <= `V_LATCH_CODE` returns the block to STARTUP.
- R6: The STARTUP → RUN → LATCHOFF → STARTUP loop repeats with no outside action. A healthy supply after a retry brings the block back to RUN.
- R7: From any state, a temperature code >= `T_TRIP_CODE` (default 170) moves the block to THERMAL (`state_o` = 3), with `sw_en`=0, `hv_src_en`=0 and `low_pwr`=1.
- R8: THERMAL is held until the temperature code is <= `T_TRIP_CODE - T_HYST_CODE` (default 140). The block then returns to STARTUP, never directly to RUN.
- R9: `hv_src_en` and `sw_en` are never high together, and `low_pwr` is never high while either of them is high.
- R10: `sw_en` rises only on the cycle after the block was in STARTUP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| v_code | input | VW (8) | Sampled supply-rail code |
| t_code | input | TW (8) | Sampled die-temperature code |
| hv_src_en | output | 1 | Enables the high-voltage startup current source |
| sw_en | output | 1 | Allows the PWM engine to switch |
| low_pwr | output | 1 | Low-consumption flag (latch-off or thermal) |
| state_o | output | 2 | State code: 0 STARTUP, 1 RUN, 2 LATCHOFF, 3 THERMAL |

## Verification
The hardest behaviour to reach is the order of the hiccup loop inside LATCHOFF. The supply code first has to fall below the minimum level from RUN. It then has to rise above the turn-on level while still latched, which must not restart the block. Only after that does it drain to the lowest level. The stimulus table walks the supply code through exactly this ramp. It then crosses a thermal trip from both RUN and LATCHOFF. Directed tests place a crossing that holds one sample short of the qualification window, and they measure the exact edge on which RUN is entered.

// File: rtl/sup_seq_pkg.sv
package sup_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_START = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_HOLD  = 2'd2,
    SEQ_HOT   = 2'd3
  } seq_state_e;

  // Index of each qualified condition in the condition vector
  localparam int C_VUP   = 0;
  localparam int C_VLOW  = 1;
  localparam int C_VDRN  = 2;
  localparam int C_THOT  = 3;
  localparam int C_TCOOL = 4;
  localparam int NCOND   = 5;
endpackage

// File: rtl/sup_seq_rst_sync.sv
module sup_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/sup_seq_qual.sv
module sup_seq_qual #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic qual
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] NMAX = CW'(N);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    if (!cond)             cnt_d = '0;
    else if (cnt_q == NMAX) begin
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
    end else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign qual = (cnt_q == NMAX);
endmodule

// File: rtl/sup_seq_fsm.sv
module sup_seq_fsm
  import sup_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCOND-1:0] q,
  output seq_state_e       state,
  output logic             hv_src_en,
  output logic             sw_en,
  output logic             low_pwr
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (q[C_THOT]) begin
      state_d = SEQ_HOT;
    end else begin
      unique case (state_q)
        SEQ_START: if (q[C_VUP])   state_d = SEQ_RUN;
        SEQ_RUN:   if (q[C_VLOW])  state_d = SEQ_HOLD;
        SEQ_HOLD:  if (q[C_VDRN])  state_d = SEQ_START;
        SEQ_HOT:   if (q[C_TCOOL]) state_d = SEQ_START;
        default:                   state_d = SEQ_START;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_START;
    else        state_q <= state_d;
  end

  assign state     = state_q;
  assign hv_src_en = (state_q == SEQ_START);
  assign sw_en     = (state_q == SEQ_RUN);
  assign low_pwr   = (state_q == SEQ_HOLD) || (state_q == SEQ_HOT);
endmodule

// File: rtl/sup_seq_top.sv
module sup_seq_top
  import sup_seq_pkg::*;
#(
  parameter int VW           = 8,
  parameter int TW           = 8,
  parameter int V_ON_CODE    = 128,
  parameter int V_MIN_CODE   = 78,
  parameter int V_LATCH_CODE = 49,
  parameter int T_TRIP_CODE  = 170,
  parameter int T_HYST_CODE  = 30,
  parameter int QUAL_N       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] v_code,
  input  logic [TW-1:0] t_code,
  output logic          hv_src_en,
  output logic          sw_en,
  output logic          low_pwr,
  output logic [1:0]    state_o
);
  localparam logic [VW-1:0] VON  = VW'(V_ON_CODE);
  localparam logic [VW-1:0] VMIN = VW'(V_MIN_CODE);
  localparam logic [VW-1:0] VLAT = VW'(V_LATCH_CODE);
  localparam logic [TW-1:0] TTRP = TW'(T_TRIP_CODE);
  localparam logic [TW-1:0] TREL = TW'(T_TRIP_CODE - T_HYST_CODE);

  logic             rst_n_s;
  logic [NCOND-1:0] cond, qual;
  seq_state_e       st;

  sup_seq_rst_sync #(.STAGES(2)) rsync_i (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  always_comb begin
    cond          = '0;
    cond[C_VUP]   = (v_code >= VON);
    cond[C_VLOW]  = (v_code <  VMIN);
    cond[C_VDRN]  = (v_code <= VLAT);
    cond[C_THOT]  = (t_code >= TTRP);
    cond[C_TCOOL] = (t_code <= TREL);
  end

  for (genvar g = 0; g < NCOND; g++) begin : g_qual
    sup_seq_qual #(.N(QUAL_N)) qual_i (
      .clk(clk), .rst_n(rst_n_s), .cond(cond[g]), .qual(qual[g])
    );
  end

  sup_seq_fsm fsm_i (
    .clk(clk), .rst_n(rst_n_s), .q(qual), .state(st),
    .hv_src_en(hv_src_en), .sw_en(sw_en), .low_pwr(low_pwr)
  );

  assign state_o = st;
endmodule

// File: rtl/sup_seq_chk.sv
module sup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hv_src_en,
  input logic       sw_en,
  input logic       low_pwr,
  input logic [1:0] state_o
);
  // R9
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hv_src_en && sw_en));

  // R9
  lowpwr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_pwr |-> (!hv_src_en && !sw_en));

  // R10
  sw_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> ($past(state_o) == 2'd0));

  // R4
  run_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1) |=> (state_o != 2'd0));

  // R5
  hold_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2) |=> (state_o != 2'd1));

  // R8
  hot_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3) |=> (state_o == 2'd3 || state_o == 2'd0));
endmodule

bind sup_seq_top sup_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .hv_src_en(hv_src_en), .sw_en(sw_en),
  .low_pwr(low_pwr), .state_o(state_o)
);

// File: tb/sup_seq_tb.sv
module sup_seq_top_tb_top;
  logic       clk;
  logic       rst_n;
  logic [7:0] v_code, t_code;
  logic       hv_src_en, sw_en, low_pwr;
  logic [1:0] state_o;
  int checks;
  int fails;
  bit done;

  sup_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .v_code(v_code), .t_code(t_code),
    .hv_src_en(hv_src_en), .sw_en(sw_en), .low_pwr(low_pwr),
    .state_o(state_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {v_code, t_code, cycles, expected state}
  localparam int NV = 16;
  localparam logic [33:0] VEC [NV] = '{
    {8'd0,   8'd25,  16'd10, 2'd0},  // R1 idle charge
    {8'd100, 8'd25,  16'd10, 2'd0},  // R2 below turn-on
    {8'd130, 8'd25,  16'd10, 2'd1},  // R2 turn-on
    {8'd100, 8'd25,  16'd10, 2'd1},  // R4 above minimum keeps RUN
    {8'd70,  8'd25,  16'd10, 2'd2},  // R4 undervoltage
    {8'd130, 8'd25,  16'd10, 2'd2},  // R5 no restart while latched
    {8'd60,  8'd25,  16'd10, 2'd2},  // R5 still above drain level
    {8'd45,  8'd25,  16'd10, 2'd0},  // R5 R6 retry
    {8'd130, 8'd25,  16'd10, 2'd1},  // R6 recovery
    {8'd130, 8'd175, 16'd10, 2'd3},  // R7 trip from RUN
    {8'd130, 8'd150, 16'd10, 2'd3},  // R8 inside hysteresis
    {8'd100, 8'd135, 16'd10, 2'd0},  // R8 release to STARTUP
    {8'd130, 8'd135, 16'd10, 2'd1},  // R6 run again
    {8'd70,  8'd25,  16'd10, 2'd2},  // R4 latch again
    {8'd70,  8'd180, 16'd10, 2'd3},  // R7 trip from LATCHOFF
    {8'd45,  8'd100, 16'd10, 2'd0}   // R8 release
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [1:0] exp);
    chk({req, " state"}, state_o, exp);
    chk({req, " hv_src_en"}, hv_src_en, exp == 2'd0);
    chk({req, " sw_en"}, sw_en, exp == 2'd1);
    chk({req, " low_pwr"}, low_pwr, exp[1]);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; v_code = 8'd200; t_code = 8'd25;
    cyc(3);
    chk_state("R1 in reset", 2'd0);
    rst_n = 1'b1;
    cyc(2);
    v_code = 8'd0;
    cyc(10);
    chk_state("R1 after reset", 2'd0);

    for (int k = 0; k < NV; k++) begin
      v_code = VEC[k][33:26];
      t_code = VEC[k][25:18];
      cyc(int'(VEC[k][17:2]));
      chk_state($sformatf("vec%0d", k), VEC[k][1:0]);
    end

    // R2 exact latency: STARTUP with v below turn-on, then cross
    v_code = 8'd100; t_code = 8'd25;
    cyc(10);
    v_code = 8'd128;
    cyc(4);
    chk_state("R2 edge N", 2'd0);
    cyc(1);
    chk_state("R2 edge N+1", 2'd1);

    // R3 glitch of N-1 samples below minimum: stays RUN
    v_code = 8'd77;
    cyc(3);
    v_code = 8'd100;
    cyc(10);
    chk_state("R3 short sag", 2'd1);

    // R3 short thermal spike
    t_code = 8'd170;
    cyc(3);
    t_code = 8'd25;
    cyc(10);
    chk_state("R3 short spike", 2'd1);

    // R4 boundary: exactly minimum keeps RUN
    v_code = 8'd78;
    cyc(10);
    chk_state("R4 at minimum", 2'd1);
    v_code = 8'd77;
    cyc(10);
    chk_state("R4 below minimum", 2'd2);

    // R5 boundary: 50 holds, 49 releases
    v_code = 8'd50;
    cyc(10);
    chk_state("R5 above drain", 2'd2);
    v_code = 8'd49;
    cyc(10);
    chk_state("R5 at drain", 2'd0);

    // R8 boundary: 141 holds, 140 releases
    t_code = 8'd170;
    cyc(10);
    chk_state("R7 at trip", 2'd3);
    t_code = 8'd141;
    cyc(10);
    chk_state("R8 band edge", 2'd3);
    t_code = 8'd140;
    cyc(10);
    chk_state("R8 release edge", 2'd0);

    // R1 reset while running
    v_code = 8'd130;
    cyc(10);
    chk_state("R2 pre-reset run", 2'd1);
    rst_n = 1'b0;
    cyc(1);
    chk_state("R1 async reset", 2'd0);
    rst_n = 1'b1;
    cyc(1);
    chk_state("R1 post release", 2'd0);

    done = 1;
    finish_run();
  end
endmodule